// File: doc/BRIEF.md
# I2C Output Port Expander

This block is an I2C target that owns an eight-bit output port. A bus controller writes bytes to it, and each byte it receives is copied straight onto all eight outputs. There is no register pointer: the block holds one byte of state, and every data byte in a write replaces the whole port. Reads return the real levels seen on the port pins. The pins are sampled anew in every acknowledge slot, so a pin that an outside driver holds against the latch reads back at the forced level.

SCL and SDA are brought into the system clock domain through synchronisers and edge-detected there. SDA is driven as an open-drain line through an output enable. The top three address bits are fixed and a four-bit strap supplies the low four, which gives sixteen selectable addresses. Clock stretching, general call and ten-bit addressing are not part of the block.

Top module: `i2c_port_expander`

## Requirements
- R1: During and after reset, `port_out` is 0xFF and `sda_oe` is 0 (SDA released).
- R2: The 7-bit address is `{3'b101, addr_strap}`, sent MSB first, followed by a direction bit (0 = write, 1 = read). On a match the block holds SDA low for the whole high phase of the ninth clock, for both directions.
- R3: On an address mismatch the block leaves SDA released until the next START. Any data clocked in before that START is neither acknowledged nor written to `port_out`.
- R4: In a write, every data byte (MSB first) is acknowledged and loaded into all eight bits of `port_out`. This repeats for any number of bytes until STOP.
- R5: In a read, `port_pin` is sampled during the acknowledge slot that comes before a data byte, and that sample is shifted out MSB first. Pin changes after the sample do not affect the byte being sent, and the value reflects the pins, not the output latch.
- R6: In a multibyte read the controller supplies the acknowledge bit (SDA low = continue). After each controller ACK the pins are sampled again and the new sample is sent as the next byte.
- R7: If the controller NACKs a read byte, the block releases SDA and sends no further data until a START.
- R8: A START or repeated START seen in any state, including partway through a byte, restarts address reception. A byte that was cut short does not change `port_out`.
- R9: The block changes its SDA drive only while SCL is low, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| addr_strap | input | 4 | Low four bits of the target address |
| port_out | output | 8 | Output port latch |
| port_pin | input | 8 | Actual levels seen on the port pins |

## Verification
On every cycle the assertions check four things: the SDA drive only moves after an SCL fall or a bus condition, the acknowledge drive is held through its slot, the line stays released in the controller-acknowledge slot and after a mismatch, and the port latch changes only when a complete write byte arrives. A START is also checked to put the block back into address reception with SDA released. Whether the right addresses are matched, which byte values appear on the port, and which pin snapshot goes out in each read byte can only be shown by the bench. It sweeps every address against a fixed strap, every strap value, multibyte writes, reads with pins forced against the latch and changed between bytes, controller NACK, and restarts partway through a byte.

// File: rtl/pe_pkg.sv
package pe_pkg;

    localparam int PE_BYTE_W  = 8;
    localparam int PE_STRAP_W = 4;
    localparam int PE_FIX_W   = 7 - PE_STRAP_W;
    localparam int PE_CNT_W   = $clog2(PE_BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_PEND,
        ST_ACK_DRV,
        ST_WDATA,
        ST_RDATA,
        ST_MACK,
        ST_WAIT
    } pe_state_e;

    typedef struct packed {
        pe_state_e              st;
        logic [PE_CNT_W-1:0]    bitcnt;
        logic [PE_BYTE_W-1:0]   shreg;
        logic [PE_BYTE_W-1:0]   port;
        logic                   oe;
        logic                   rd;
        logic                   cont;
    } pe_regs_t;

endpackage

// File: rtl/pe_line_sync.sv
module pe_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] stage_d, stage_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb stage_d = raw_i;
        end else begin : g_chain
            always_comb stage_d = {stage_q[STAGES-2:0], raw_i};
        end
    endgenerate

    always_comb begin
        prev_d = stage_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            stage_q <= stage_d;
            prev_q  <= prev_d;
        end
    end

    assign level_o = stage_q[STAGES-1];
    assign rise_o  = stage_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pe_cond_detect.sv
module pe_cond_detect (
    input  logic scl_lvl,
    input  logic scl_rise,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    logic scl_steady_high;

    always_comb begin
        scl_steady_high = scl_lvl & ~scl_rise;
        start_o         = sda_fall & scl_steady_high;
        stop_o          = sda_rise & scl_steady_high;
    end
endmodule

// File: rtl/pe_engine.sv
module pe_engine
    import pe_pkg::*;
#(
    parameter logic [PE_FIX_W-1:0]  ADDR_HI   = 3'b101,
    parameter logic [PE_BYTE_W-1:0] RESET_VAL = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   sda_lvl,
    input  logic                   start,
    input  logic                   stop,
    input  logic [PE_STRAP_W-1:0]  strap,
    input  logic [PE_BYTE_W-1:0]   pins,
    output logic                   sda_oe,
    output logic [PE_BYTE_W-1:0]   port
);
    localparam logic [PE_CNT_W-1:0] LAST_BIT = PE_CNT_W'(PE_BYTE_W - 1);
    localparam logic [PE_CNT_W-1:0] FULL_CNT = PE_CNT_W'(PE_BYTE_W);

    pe_regs_t r_d, r_q;
    logic [PE_BYTE_W-1:0] shifted_in;
    logic                 addr_hit;

    always_comb begin
        shifted_in = {r_q.shreg[PE_BYTE_W-2:0], sda_lvl};
        addr_hit   = (r_q.shreg[6:0] == {ADDR_HI, strap});
        r_d        = r_q;

        if (start) begin
            r_d.st     = ST_ADDR;
            r_d.bitcnt = '0;
            r_d.oe     = 1'b0;
            r_d.cont   = 1'b0;
        end else if (stop) begin
            r_d.st     = ST_IDLE;
            r_d.oe     = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        r_d.shreg  = shifted_in;
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                        if (r_q.bitcnt == LAST_BIT) begin
                            r_d.bitcnt = '0;
                            r_d.rd     = sda_lvl;
                            r_d.st     = addr_hit ? ST_ACK_PEND : ST_WAIT;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        r_d.shreg  = shifted_in;
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                        if (r_q.bitcnt == LAST_BIT) begin
                            r_d.bitcnt = '0;
                            r_d.port   = shifted_in;
                            r_d.st     = ST_ACK_PEND;
                        end
                    end
                end
                ST_ACK_PEND: begin
                    if (scl_fall) begin
                        r_d.oe = 1'b1;
                        r_d.st = ST_ACK_DRV;
                    end
                end
                ST_ACK_DRV: begin
                    if (scl_rise) begin
                        if (r_q.rd) begin
                            r_d.shreg = pins;
                        end
                    end else if (scl_fall) begin
                        r_d.bitcnt = '0;
                        if (r_q.rd) begin
                            r_d.st = ST_RDATA;
                            r_d.oe = ~r_q.shreg[PE_BYTE_W-1];
                        end else begin
                            r_d.st = ST_WDATA;
                            r_d.oe = 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        r_d.bitcnt = r_q.bitcnt + 1'b1;
                    end else if (scl_fall) begin
                        if (r_q.bitcnt == FULL_CNT) begin
                            r_d.oe     = 1'b0;
                            r_d.bitcnt = '0;
                            r_d.st     = ST_MACK;
                        end else begin
                            r_d.shreg = {r_q.shreg[PE_BYTE_W-2:0], 1'b0};
                            r_d.oe    = ~r_q.shreg[PE_BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.cont = ~sda_lvl;
                        if (!sda_lvl) begin
                            r_d.shreg = pins;
                        end
                    end else if (scl_fall) begin
                        if (r_q.cont) begin
                            r_d.st = ST_RDATA;
                            r_d.oe = ~r_q.shreg[PE_BYTE_W-1];
                        end else begin
                            r_d.st = ST_WAIT;
                            r_d.oe = 1'b0;
                        end
                    end
                end
                default: begin
                    r_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.bitcnt <= '0;
            r_q.shreg  <= '0;
            r_q.port   <= RESET_VAL;
            r_q.oe     <= 1'b0;
            r_q.rd     <= 1'b0;
            r_q.cont   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.oe;
    assign port   = r_q.port;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.oe) |-> $past(scl_fall || start || stop)); // R9

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ACK_DRV) |-> r_q.oe); // R2

    AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> !r_q.oe); // R3

    AST_PORT_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.port) |-> $past(r_q.st == ST_WDATA && scl_rise && r_q.bitcnt == LAST_BIT)); // R4

    AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MACK) |-> !r_q.oe); // R6

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (r_q.st == ST_ADDR && !r_q.oe)); // R8
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
    import pe_pkg::*;
#(
    parameter int                   SYNC_STAGES = 2,
    parameter logic [PE_FIX_W-1:0]  ADDR_HI     = 3'b101,
    parameter logic [PE_BYTE_W-1:0] RESET_VAL   = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [PE_STRAP_W-1:0]  addr_strap,
    output logic [PE_BYTE_W-1:0]   port_out,
    input  logic [PE_BYTE_W-1:0]   port_pin
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start, stop;

    pe_line_sync #(.STAGES(SYNC_STAGES)) i_scl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (scl_i),
        .level_o (scl_lvl),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    pe_line_sync #(.STAGES(SYNC_STAGES)) i_sda_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (sda_i),
        .level_o (sda_lvl),
        .rise_o  (sda_rise),
        .fall_o  (sda_fall)
    );

    pe_cond_detect i_cond (
        .scl_lvl  (scl_lvl),
        .scl_rise (scl_rise),
        .sda_rise (sda_rise),
        .sda_fall (sda_fall),
        .start_o  (start),
        .stop_o   (stop)
    );

    pe_engine #(.ADDR_HI(ADDR_HI), .RESET_VAL(RESET_VAL)) i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start    (start),
        .stop     (stop),
        .strap    (addr_strap),
        .pins     (port_pin),
        .sda_oe   (sda_oe),
        .port     (port_out)
    );
endmodule

// File: tb/test_i2c_port_expander.sv
module test_i2c_port_expander;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [3:0] strap = 4'b1010;
    logic [7:0] fen = 8'h00;
    logic [7:0] fval = 8'h00;
    logic       sda_oe;
    logic [7:0] port_out;
    logic       sda_bus;
    logic [7:0] port_pin;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] exp_port = 8'hFF;

    always #10 clk = ~clk;

    assign sda_bus  = sda_m & ~sda_oe;
    assign port_pin = (port_out & ~fen) | (fval & fen);

    i2c_port_expander i_i2c_port_expander (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe     (sda_oe),
        .addr_strap (strap),
        .port_out   (port_out),
        .port_pin   (port_pin)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw();
        qw();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic get_bit(output logic b, output bit steady);
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        b = sda_bus; qw();
        steady = (sda_bus == b);
        scl_m = 1'b0; qw();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack, output bit steady);
        logic nb;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(nb, steady);
        ack = ~nb;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) get_bit(v[i], s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ack, st;
        logic [7:0] v, expv;

        repeat (4) @(negedge clk);
        chk(port_out == 8'hFF, "R1 port in reset", port_out, 8'hFF);
        chk(sda_oe == 1'b0, "R1 sda in reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(port_out == 8'hFF && sda_oe == 1'b0, "R1 after reset", {port_out, 7'd0, sda_oe}, 32'hFF00);

        // R2 / R3: sweep all 128 addresses against strap 1010
        for (int a = 0; a < 128; a++) begin
            bit hit;
            hit = (a[6:0] == 7'h5A);
            do_start();
            send_byte({a[6:0], 1'b0}, ack, st);
            if (hit) begin
                chk(ack && st, "R2 match ack held (R9)", {ack, st}, 2'b11);
                send_byte(8'h3C ^ a[7:0], ack, st);
                exp_port = 8'h3C ^ a[7:0];
                chk(ack && port_out == exp_port, "R4 data byte", port_out, exp_port);
            end else begin
                chk(!ack, "R3 mismatch no ack", ack, 0);
                send_byte(8'h00, ack, st);
                chk(!ack && port_out == exp_port, "R3 data ignored", port_out, exp_port);
            end
            do_stop();
        end

        // R2: every strap value selects its own address
        for (int s = 0; s < 16; s++) begin
            strap = s[3:0];
            do_start();
            send_byte({3'b101, s[3:0], 1'b0}, ack, st);
            chk(ack, "R2 strap ack", ack, 1);
            send_byte({~s[3:0], s[3:0]}, ack, st);
            exp_port = {~s[3:0], s[3:0]};
            chk(ack && port_out == exp_port, "R2 strap write", port_out, exp_port);
            do_stop();
        end

        // R4: multibyte write, each byte reloads the port
        strap = 4'b0011;
        do_start();
        send_byte({7'h53, 1'b0}, ack, st);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'h1E + 8'(k * 8'h47), ack, st);
            exp_port = 8'h1E + 8'(k * 8'h47);
            chk(ack && port_out == exp_port, "R4 repeated byte", port_out, exp_port);
        end
        do_stop();

        // R5: read returns pin levels sampled in the address ack
        fen = 8'hF0; fval = 8'h50;
        expv = (exp_port & 8'h0F) | 8'h50;
        do_start();
        send_byte({7'h53, 1'b1}, ack, st);
        chk(ack && st, "R2 read address ack", {ack, st}, 2'b11);
        fval = 8'hA0;
        recv_byte(v);
        chk(v == expv, "R5 snapshot from pins", v, expv);
        chk(v != port_out, "R5 pins not latch", v, port_out);
        send_bit(1'b1);
        do_stop();

        // R6: multibyte read resamples at each controller ack
        do_start();
        send_byte({7'h53, 1'b1}, ack, st);
        recv_byte(v);
        expv = (exp_port & 8'h0F) | 8'hA0;
        chk(v == expv, "R6 first byte", v, expv);
        fval = 8'h30;
        send_bit(1'b0);
        recv_byte(v);
        expv = (exp_port & 8'h0F) | 8'h30;
        chk(v == expv, "R6 second byte", v, expv);
        fen = 8'h00;
        send_bit(1'b0);
        recv_byte(v);
        chk(v == exp_port, "R6 third byte", v, exp_port);
        send_bit(1'b1);
        do_stop();

        // R7: after NACK no more data
        do_start();
        send_byte({7'h53, 1'b0}, ack, st);
        send_byte(8'h00, ack, st);
        exp_port = 8'h00;
        do_stop();
        do_start();
        send_byte({7'h53, 1'b1}, ack, st);
        recv_byte(v);
        chk(v == 8'h00, "R5 zero read", v, 0);
        send_bit(1'b1);
        recv_byte(v);
        chk(v == 8'hFF && sda_oe == 1'b0, "R7 released after nack", v, 8'hFF);

        // R8: repeated start from the wait state
        do_start();
        send_byte({7'h53, 1'b0}, ack, st);
        chk(ack, "R8 restart address ack", ack, 1);
        send_byte(8'h69, ack, st);
        exp_port = 8'h69;
        chk(ack && port_out == exp_port, "R8 write after restart", port_out, exp_port);

        // R8: repeated start partway through a data byte
        for (int i = 7; i >= 4; i--) send_bit(1'b0);
        do_start();
        chk(port_out == exp_port && sda_oe == 1'b0, "R8 partial byte dropped", port_out, exp_port);
        send_byte({7'h53, 1'b0}, ack, st);
        send_byte(8'hC5, ack, st);
        exp_port = 8'hC5;
        chk(ack && port_out == exp_port, "R8 write after mid-byte restart", port_out, exp_port);
        do_stop();
        chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule